// File: doc/BRIEF.md
# Block Walsh-Hadamard Code-Phase Correlator

This block takes a block of 1024 signed samples and computes its full 1024-point Walsh-Hadamard transform. When the received samples are reordered by a fixed index mapping upstream, one transform yields the correlation against every code phase at once. The transform uses only additions and subtractions. Each butterfly pair puts the sum on one leg and the difference on the other.

A 1024-point transform is too large to build as a single parallel network. It is therefore built from 64 passes through one combinational 32-point butterfly engine. The samples are arranged as a 32 by 32 grid, with sample index n = 32·row + column. The first pass transforms each row and stores the results in an intermediate RAM. The second pass reads that RAM column by column, transforms each column and streams the results out. A peak search follows the output stream. It reports the largest magnitude and its index, then pulses `done`.

A block is started with `blk_start` while the block is idle. After that, the block takes 1024 samples on the cycles where `smp_valid` is high. It accepts nothing more until the transform has finished.

Top module: `whcorr_top`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are 0, and `peak_val` and `peak_idx` are 0.
- R2: The block accepts `blk_start` only while `busy` is 0. Starting on the following cycle, the samples on the next 1024 cycles with `smp_valid` high are stored as x[0]..x[1023] in arrival order. Cycles with `smp_valid` low add no sample. A sample presented while idle, or in the same cycle as `blk_start`, is not stored.
- R3: Each result is Y[k] = Σ x[n]·(−1)^popcount(k AND n), where n and k are 10-bit indices. It is exact and given as a 22-bit two's-complement value on `out_data`.
- R4: Each block produces exactly 1024 `out_valid` cycles, and `out_idx` carries k. The outputs appear in groups of 32. Group g (g = 0..31) carries k = 32·j + g for j = 0..31 in that order. Each group follows a 32-cycle gap. The first `out_valid` rises on the 2081st rising edge after the edge that stores x[1023].
- R5: `peak_val` is the largest |Y[k]| over the block, as an unsigned 22-bit value. `peak_idx` is the smallest k that reaches that magnitude, even when a larger k with the same magnitude comes out earlier.
- R6: `done` is high for exactly one cycle, the cycle right after the final `out_valid`. That is the 4097th rising edge after the edge that stores x[1023]. `peak_val` and `peak_idx` are final while `done` is high and keep their values afterwards.
- R7: `blk_start` and `smp_valid` are ignored while a block is being transformed. The results of that block do not change.
- R8: `busy` is 1 from the cycle after an accepted `blk_start` until the last result has been emitted. It is 0 by the time `done` is high, so a new block can start at once.
- R9: Full-scale input is handled without overflow. All samples at −2048 give Y[0] = −2097152 and `peak_val` = 2097152.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| blk_start | input | 1 | Begins a new block when idle |
| smp_valid | input | 1 | Marks a sample on `smp_data` |
| smp_data | input | 12 | Signed input sample |
| busy | output | 1 | A block is loading or being transformed |
| out_valid | output | 1 | `out_idx` and `out_data` carry a result |
| out_idx | output | 10 | Transform index k of the current result |
| out_data | output | 22 | Signed transform result Y[k] |
| done | output | 1 | One-cycle pulse after the last result |
| peak_val | output | 22 | Largest result magnitude of the last block |
| peak_idx | output | 10 | Lowest index holding that magnitude |

## Verification
The result stream is due on fixed edges. The first `out_valid` comes 2081 edges after the edge that stores the final sample, and `done` comes 4097 edges after it. The bench counts cycles from that point and checks both instants exactly. It samples on the falling edge, so each registered output is read in the cycle it becomes valid. Every value seen with `out_valid` high is compared, by its position in the stream and by its index, against a direct Hadamard product that the bench computes itself. The peak, the one-cycle width of `done` and the held peak values are checked in the `done` cycle and in the cycle after it.

// File: rtl/whcorr_pkg.sv
package whcorr_pkg;

  // Sequencer phases: load, row pass (gather/put), column pass (gather/put)
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LOAD    = 3'd1,
    PH_ROW_GET = 3'd2,
    PH_ROW_PUT = 3'd3,
    PH_COL_GET = 3'd4,
    PH_COL_PUT = 3'd5
  } phase_t;

endpackage

// File: rtl/whcorr_ram.sv
module whcorr_ram #(
  parameter int W  = 12,
  parameter int AW = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/whcorr_fwht.sv
module whcorr_fwht #(
  parameter int IN_W = 17,
  parameter int LG   = 5,
  localparam int N     = 1 << LG,
  localparam int OUT_W = IN_W + LG
) (
  input  logic signed [IN_W-1:0]  din  [N],
  output logic signed [OUT_W-1:0] dout [N]
);

  // Stage s pairs lanes j and j+2^s; lower lane takes the sum, upper the difference.
  logic signed [OUT_W-1:0] stg [LG+1][N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      stg[0][i] = OUT_W'(din[i]);
    end
    for (int s = 0; s < LG; s++) begin
      for (int j = 0; j < N; j++) begin
        if (((j >> s) & 1) == 0) begin
          stg[s+1][j] = stg[s][j] + stg[s][j + (1 << s)];
        end else begin
          stg[s+1][j] = stg[s][j - (1 << s)] - stg[s][j];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      dout[i] = stg[LG][i];
    end
  end

endmodule

// File: rtl/whcorr_ctrl.sv
module whcorr_ctrl
  import whcorr_pkg::*;
#(
  parameter int LINE_LG = 5,
  localparam int BLK_LG = 2 * LINE_LG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blk_start,
  input  logic               smp_valid,
  output logic               busy,
  output logic               a_we,
  output logic [BLK_LG-1:0]  a_waddr,
  output logic [BLK_LG-1:0]  a_raddr,
  output logic               b_we,
  output logic [BLK_LG-1:0]  b_waddr,
  output logic [BLK_LG-1:0]  b_raddr,
  output logic               buf_we,
  output logic               col_pass,
  output logic [LINE_LG-1:0] slot,
  output logic               emit,
  output logic               emit_first,
  output logic               emit_last,
  output logic [BLK_LG-1:0]  emit_idx
);

  localparam logic [LINE_LG-1:0] SLOT_END = '1;
  localparam logic [BLK_LG-1:0]  LOAD_END = '1;

  phase_t             ph_q, ph_d;
  logic [BLK_LG-1:0]  ld_q, ld_d;
  logic [LINE_LG-1:0] cnt_q, cnt_d;
  logic [LINE_LG-1:0] line_q, line_d;
  logic               cnt_end, line_end;

  assign cnt_end  = (cnt_q == SLOT_END);
  assign line_end = (line_q == SLOT_END);

  // next-state
  always_comb begin
    ph_d   = ph_q;
    ld_d   = ld_q;
    cnt_d  = cnt_q;
    line_d = line_q;
    case (ph_q)
      PH_IDLE: begin
        if (blk_start) begin
          ph_d = PH_LOAD;
          ld_d = '0;
        end
      end
      PH_LOAD: begin
        if (smp_valid) begin
          ld_d = ld_q + 1'b1;
          if (ld_q == LOAD_END) begin
            ph_d   = PH_ROW_GET;
            cnt_d  = '0;
            line_d = '0;
          end
        end
      end
      PH_ROW_GET: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_end) ph_d = PH_ROW_PUT;
      end
      PH_ROW_PUT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_end) begin
          line_d = line_q + 1'b1;
          ph_d   = line_end ? PH_COL_GET : PH_ROW_GET;
        end
      end
      PH_COL_GET: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_end) ph_d = PH_COL_PUT;
      end
      PH_COL_PUT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_end) begin
          line_d = line_q + 1'b1;
          ph_d   = line_end ? PH_IDLE : PH_COL_GET;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      ld_q   <= '0;
      cnt_q  <= '0;
      line_q <= '0;
    end else begin
      ph_q   <= ph_d;
      ld_q   <= ld_d;
      cnt_q  <= cnt_d;
      line_q <= line_d;
    end
  end

  // decoded strobes and addresses; rows are n[9:5], columns n[4:0]
  always_comb begin
    busy       = (ph_q != PH_IDLE);
    a_we       = (ph_q == PH_LOAD) && smp_valid;
    a_waddr    = ld_q;
    a_raddr    = {line_q, cnt_q};
    b_we       = (ph_q == PH_ROW_PUT);
    b_waddr    = {line_q, cnt_q};
    b_raddr    = {cnt_q, line_q};
    buf_we     = (ph_q == PH_ROW_GET) || (ph_q == PH_COL_GET);
    col_pass   = (ph_q == PH_COL_GET) || (ph_q == PH_COL_PUT);
    slot       = cnt_q;
    emit       = (ph_q == PH_COL_PUT);
    emit_idx   = {cnt_q, line_q};
    emit_first = emit && (cnt_q == '0) && (line_q == '0);
    emit_last  = emit && cnt_end && line_end;
  end

  AST_START_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && ph_q != PH_LOAD && blk_start) |=> (ph_q != PH_LOAD)); // R7

  AST_LOAD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !blk_start) |=> (ph_q == PH_IDLE)); // R2

endmodule

// File: rtl/whcorr_peak.sv
module whcorr_peak #(
  parameter int DW = 22,
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [DW-1:0] in_data,
  input  logic [IW-1:0] in_idx,
  output logic          done,
  output logic [DW-1:0] peak_val,
  output logic [IW-1:0] peak_idx
);

  logic [DW-1:0] mag;
  logic          take;
  logic [DW-1:0] best_q, best_d;
  logic [IW-1:0] bidx_q, bidx_d;
  logic          done_q, done_d;

  // magnitude fits unsigned DW bits, including the most negative input
  assign mag = in_data[DW-1] ? DW'(~in_data + 1'b1) : in_data;

  always_comb begin
    take   = in_valid && (in_first || (mag > best_q) ||
                          ((mag == best_q) && (in_idx < bidx_q)));
    best_d = take ? mag : best_q;
    bidx_d = take ? in_idx : bidx_q;
    done_d = in_valid && in_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_q <= '0;
      bidx_q <= '0;
      done_q <= 1'b0;
    end else begin
      best_q <= best_d;
      bidx_q <= bidx_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign peak_val = best_q;
  assign peak_idx = bidx_q;

  AST_PEAK_NONDECR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first) |=> (peak_val >= $past(peak_val))); // R5

  AST_PEAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(peak_val) && $stable(peak_idx))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

endmodule

// File: rtl/whcorr_top.sv
module whcorr_top
  import whcorr_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int LINE_LG = 5,
  localparam int BLK_LG = 2 * LINE_LG,
  localparam int OUT_W  = SMP_W + BLK_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              busy,
  output logic              out_valid,
  output logic [BLK_LG-1:0] out_idx,
  output logic [OUT_W-1:0]  out_data,
  output logic              done,
  output logic [OUT_W-1:0]  peak_val,
  output logic [BLK_LG-1:0] peak_idx
);

  localparam int LINE_N = 1 << LINE_LG;
  localparam int MID_W  = SMP_W + LINE_LG;
  localparam int BLK_N  = 1 << BLK_LG;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic               a_we, b_we, buf_we, col_pass;
  logic               emit, emit_first, emit_last;
  logic [BLK_LG-1:0]  a_waddr, a_raddr, b_waddr, b_raddr, emit_idx;
  logic [LINE_LG-1:0] slot;
  logic [SMP_W-1:0]   a_rdata;
  logic [MID_W-1:0]   b_rdata;

  whcorr_ctrl #(.LINE_LG(LINE_LG)) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .blk_start (blk_start),
    .smp_valid (smp_valid),
    .busy      (busy),
    .a_we      (a_we),
    .a_waddr   (a_waddr),
    .a_raddr   (a_raddr),
    .b_we      (b_we),
    .b_waddr   (b_waddr),
    .b_raddr   (b_raddr),
    .buf_we    (buf_we),
    .col_pass  (col_pass),
    .slot      (slot),
    .emit      (emit),
    .emit_first(emit_first),
    .emit_last (emit_last),
    .emit_idx  (emit_idx)
  );

  whcorr_ram #(.W(SMP_W), .AW(BLK_LG)) u_smp_ram (
    .clk  (clk),
    .we   (a_we),
    .waddr(a_waddr),
    .wdata(smp_data),
    .raddr(a_raddr),
    .rdata(a_rdata)
  );

  // gather buffer shared by both passes
  logic signed [MID_W-1:0] buf_din;
  logic signed [MID_W-1:0] gbuf [LINE_N];
  logic signed [OUT_W-1:0] xf   [LINE_N];
  logic signed [OUT_W-1:0] xf_sel;

  assign buf_din = col_pass ? $signed(b_rdata) : MID_W'($signed(a_rdata));

  for (genvar g = 0; g < LINE_N; g++) begin : g_gbuf
    logic ld_en;
    assign ld_en = buf_we && (slot == LINE_LG'(g));
    always_ff @(posedge clk) begin
      if (ld_en) gbuf[g] <= buf_din;
    end
  end

  whcorr_fwht #(.IN_W(MID_W), .LG(LINE_LG)) u_fwht (
    .din (gbuf),
    .dout(xf)
  );

  assign xf_sel = xf[slot];

  // row results need only MID_W bits
  whcorr_ram #(.W(MID_W), .AW(BLK_LG)) u_mid_ram (
    .clk  (clk),
    .we   (b_we),
    .waddr(b_waddr),
    .wdata(xf_sel[MID_W-1:0]),
    .raddr(b_raddr),
    .rdata(b_rdata)
  );

  // output stream register
  logic              ov_q, of_q, ol_q;
  logic [OUT_W-1:0]  od_q, od_d;
  logic [BLK_LG-1:0] oi_q, oi_d;

  always_comb begin
    od_d = emit ? xf_sel : od_q;
    oi_d = emit ? emit_idx : oi_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ov_q <= 1'b0;
      of_q <= 1'b0;
      ol_q <= 1'b0;
      od_q <= '0;
      oi_q <= '0;
    end else begin
      ov_q <= emit;
      of_q <= emit_first;
      ol_q <= emit_last;
      od_q <= od_d;
      oi_q <= oi_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_idx   = oi_q;

  whcorr_peak #(.DW(OUT_W), .IW(BLK_LG)) u_peak (
    .clk     (clk),
    .rst_n   (srst_n),
    .in_valid(ov_q),
    .in_first(of_q),
    .in_last (ol_q),
    .in_data (od_q),
    .in_idx  (oi_q),
    .done    (done),
    .peak_val(peak_val),
    .peak_idx(peak_idx)
  );

  // count emitted results for the block-length check
  logic [BLK_LG:0] seen_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        seen_q <= '0;
    else if (done)      seen_q <= '0;
    else if (out_valid) seen_q <= seen_q + 1'b1;
  end

  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> (seen_q == (BLK_LG+1)'(BLK_N))); // R4

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> !busy); // R8

endmodule

// File: tb/whcorr_top_bench.sv
module whcorr_top_bench;

  localparam int NS = 1024;

  logic        clk;
  logic        rst_n;
  logic        blk_start;
  logic        smp_valid;
  logic [11:0] smp_data;
  logic        busy;
  logic        out_valid;
  logic [9:0]  out_idx;
  logic [21:0] out_data;
  logic        done;
  logic [21:0] peak_val;
  logic [9:0]  peak_idx;

  whcorr_top u_whcorr_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_start(blk_start),
    .smp_valid(smp_valid),
    .smp_data (smp_data),
    .busy     (busy),
    .out_valid(out_valid),
    .out_idx  (out_idx),
    .out_data (out_data),
    .done     (done),
    .peak_val (peak_val),
    .peak_idx (peak_idx)
  );

  int n_vec = 0;
  int n_bad = 0;
  int xs [NS];
  int ey [NS];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sgn_of(input int k, input int n);
    return ($countones(k & n) % 2 == 0) ? 1 : -1;
  endfunction

  // Drive one block from xs and check the stream, peak and done.
  task automatic run_block(input string tag, input bit gaps,
                           input bit idle_noise, input bit disturb);
    int     bestm, besti, seen, first_cyc;
    bit     prev_v, got_done;
    longint held_v, held_i;
    for (int k = 0; k < NS; k++) begin
      int acc = 0;
      for (int n = 0; n < NS; n++) acc += xs[n] * sgn_of(k, n);
      ey[k] = acc;
    end
    bestm = -1; besti = 0;
    for (int k = 0; k < NS; k++) begin
      int m = (ey[k] < 0) ? -ey[k] : ey[k];
      if (m > bestm) begin bestm = m; besti = k; end
    end
    if (idle_noise) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 12'h5A5;
      end
    end
    @(negedge clk);
    blk_start = 1'b1; smp_valid = idle_noise; smp_data = 12'h7FF;
    for (int n = 0; n < NS; n++) begin
      @(negedge clk);
      blk_start = 1'b0;
      if (gaps && (n % 7 == 3)) begin
        smp_valid = 1'b0; smp_data = 12'hABC;
        @(negedge clk);
      end
      smp_valid = 1'b1; smp_data = 12'(xs[n]);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    chk(busy == 1'b1, "R8", {tag, " busy after load"}, busy, 1);
    seen = 0; prev_v = 1'b0; got_done = 1'b0; first_cyc = -1;
    for (int cyc = 0; cyc < 9000 && !got_done; cyc++) begin
      @(negedge clk);
      if (out_valid) begin
        int eidx = ((seen % 32) * 32) + (seen / 32);
        int got  = $signed(out_data);
        if (first_cyc < 0) begin
          first_cyc = cyc;
          chk(cyc == 2080, "R4", {tag, " first result cycle"}, cyc, 2080);
        end
        chk(int'(out_idx) == eidx, "R4", {tag, " result order"}, out_idx, eidx);
        chk(got == ey[out_idx], "R3", {tag, " transform value"}, got, ey[out_idx]);
        seen++;
      end
      if (done) begin
        got_done = 1'b1;
        chk(cyc == 4096, "R6", {tag, " done cycle"}, cyc, 4096);
        chk(prev_v, "R6", {tag, " done follows last result"}, prev_v, 1);
        chk(seen == NS, "R4", {tag, " result count"}, seen, NS);
        chk(int'(peak_val) == bestm, "R5", {tag, " peak value"}, peak_val, bestm);
        chk(int'(peak_idx) == besti, "R5", {tag, " peak index"}, peak_idx, besti);
        chk(busy == 1'b0, "R8", {tag, " idle at done"}, busy, 0);
      end
      prev_v = out_valid;
      if (disturb && cyc >= 10 && cyc < 60) begin
        blk_start = (cyc % 4 == 0); smp_valid = 1'b1; smp_data = 12'(cyc * 37);
      end else begin
        blk_start = 1'b0; smp_valid = 1'b0;
      end
    end
    if (!got_done) begin
      chk(1'b0, "R6", {tag, " done never seen"}, 0, 1);
    end else begin
      held_v = peak_val; held_i = peak_idx;
      @(negedge clk);
      chk(done == 1'b0, "R6", {tag, " done width"}, done, 0);
      chk(peak_val == held_v && peak_idx == held_i, "R6", {tag, " peak held"},
          peak_val, held_v);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; blk_start = 1'b0; smp_valid = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(peak_val == '0, "R1", "peak_val after reset", peak_val, 0);
    chk(peak_idx == '0, "R1", "peak_idx after reset", peak_idx, 0);
  endtask

  // R3 R5: single impulse, every output equal, tie resolves to index 0
  task automatic t_impulse();
    for (int n = 0; n < NS; n++) xs[n] = 0;
    xs[0] = 1000;
    run_block("impulse", 1'b0, 1'b0, 1'b0);
  endtask

  // R2: one Walsh row, idle samples and gapped valid must not disturb it
  task automatic t_walsh_row();
    for (int n = 0; n < NS; n++) xs[n] = 300 * sgn_of(10'h2A5, n);
    run_block("walsh_row", 1'b1, 1'b1, 1'b0);
  endtask

  // R9: most negative full scale
  task automatic t_full_neg();
    for (int n = 0; n < NS; n++) xs[n] = -2048;
    run_block("full_neg", 1'b0, 1'b0, 1'b0);
  endtask

  // R9: alternating extremes
  task automatic t_alt_ext();
    for (int n = 0; n < NS; n++) xs[n] = ($countones(n) % 2 == 1) ? 2047 : -2048;
    run_block("alt_extreme", 1'b0, 1'b0, 1'b0);
  endtask

  // R5: equal peaks at 0x040 (emitted first) and 0x021 (lower index)
  task automatic t_tie();
    for (int n = 0; n < NS; n++) xs[n] = 100 * (sgn_of(10'h040, n) + sgn_of(10'h021, n));
    run_block("tie", 1'b0, 1'b0, 1'b0);
  endtask

  // R7: start and samples during processing are ignored
  task automatic t_random_disturb();
    for (int n = 0; n < NS; n++) xs[n] = int'($urandom_range(4095)) - 2048;
    run_block("random_disturb", 1'b1, 1'b0, 1'b1);
  endtask

  // R8: next block straight after done
  task automatic t_back_to_back();
    for (int n = 0; n < NS; n++) xs[n] = int'($urandom_range(255)) - 128;
    run_block("back_to_back", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_walsh_row();
    t_full_neg();
    t_alt_ext();
    t_tie();
    t_random_disturb();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R6 watchdog expired: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule